// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device has left stuck. That happens when a controller reset interrupts the device partway through a transfer, and the device then keeps SDA low or waits for clocks. When `start_i` is accepted, the block takes over both lines as open-drain outputs and releases them for one half-phase. It then samples both lines and plays a fixed bit-banged pattern, with every step timed in half-phases of about 5 µs:

- an optional pseudo-stop, which pulls SDA low and then releases it while SCL stays released;
- one extra SCL pulse if the bus was not free, followed by a second sample and an optional pseudo-stop;
- nine SCL pulses that do not depend on the line levels;
- a last optional pseudo-stop.

The block accepts `start_i` only while the I2C peripheral is disabled and the bus has been claimed. At the end it releases both lines, pulses `done_o`, and reports on `bus_ok_o` whether both lines read high at the final sample. Both line inputs pass through a two-flop synchronizer. Every sample is taken in the last cycle of a half-phase.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `busy_o`, `done_o` and `bus_ok_o` are all 0. While `busy_o` is 0, neither line is driven.
- R2: A `start_i` pulse starts a sequence only when `periph_en_i`=0 and `claim_ok_i`=1. In any other case the pulse has no effect: `busy_o` stays 0 and neither line is driven.
- R3: One half-phase lasts H = CLK_FREQ_HZ/1_000_000*HALF_US clock cycles. Every interval in which `scl_oe_o` or `sda_oe_o` is 1 lasts exactly H cycles.
- R4: `busy_o` rises in the cycle after an accepted start. Both lines then stay released for the first H busy cycles, so the first drive of either line begins at busy cycle index H.
- R5: A pseudo-stop happens only when both synchronized lines read high. It drives `sda_oe_o`=1 for one half-phase and then releases SDA for one half-phase, and `scl_oe_o` stays 0 throughout.
- R6: If the first sample finds either line low, the block issues one SCL pulse (low for H, released for H), samples again, and sends a pseudo-stop if both lines are now high.
- R7: After the first pseudo-stop, or after the extra-clock step, the block issues exactly NUM_CLOCKS (default 9) SCL pulses without checking the line levels.
- R8: After those pulses, one final pseudo-stop is sent if both lines read high.
- R9: `busy_o` stays high for exactly H times the number of half-phases in the sequence. `done_o` is 1 for exactly one cycle, the first cycle with `busy_o`=0. Both lines are released from then on.
- R10: A `start_i` pulse while `busy_o`=1 is ignored. The sequence length and the number of `done_o` pulses do not change.
- R11: At `done_o`, `bus_ok_o` holds 1 if both synchronized lines were high at the final sample, and 0 otherwise. It holds that value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run the recovery sequence |
| periph_en_i | input | 1 | I2C peripheral already enabled; blocks a start |
| claim_ok_i | input | 1 | Bus has been claimed by the caller |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at completion |
| bus_ok_o | output | 1 | Both lines read high at completion |

## Verification
The bench models a target that holds SDA low until it has seen k SCL falling edges, and sweeps k from 0 to 12. It also runs the case where SCL is stuck low. Across these cases it reaches every branch of the sequence:
- a free bus;
- release on the extra clock;
- release during the nine clocks;
- release at the very last clock;
- no release at all.

A design that skipped the resample after the extra clock, miscounted the nine pulses, or sampled the lines before they settled would show a wrong pulse count, a wrong pseudo-stop count, a wrong busy length or a wrong `bus_ok_o`. Starts that are blocked by the enable or the claim, and a second start during a sequence, are checked to leave both the lines and the timing untouched.

// File: rtl/i2c_rec_pkg.sv
package i2c_rec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RELEASE,
    ST_PS_LOW,
    ST_PS_HIGH,
    ST_EXTRA_LOW,
    ST_EXTRA_HIGH,
    ST_CLK_LOW,
    ST_CLK_HIGH
  } rec_state_e;

  typedef enum logic [1:0] {
    PS_FIRST,
    PS_RETRY,
    PS_FINAL
  } ps_stage_e;

  function automatic int half_cycles(input longint freq_hz, input int half_us);
    longint c;
    c = (freq_hz / 64'd1_000_000) * longint'(half_us);
    return (c < 1) ? 1 : int'(c);
  endfunction
endpackage

// File: rtl/i2c_rec_sync.sv
module i2c_rec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '1;  // idle bus reads released
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_rec_timer.sv
module i2c_rec_timer #(
  parameter int HALF_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_rec_fsm.sv
module i2c_rec_fsm
  import i2c_rec_pkg::*;
#(
  parameter int NUM_CLOCKS = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_ok_i,
  input  logic expire_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic bus_ok_o
);
  localparam int CW = (NUM_CLOCKS > 1) ? $clog2(NUM_CLOCKS) : 1;
  localparam logic [CW-1:0] CLK_LAST = CW'(NUM_CLOCKS - 1);

  rec_state_e state_q, state_d;
  ps_stage_e  stage_q, stage_d;
  logic [CW-1:0] clk_cnt_q, clk_cnt_d;
  logic finish, both_hi, done_q, ok_q;

  assign both_hi = scl_s_i & sda_s_i;

  always_comb begin
    state_d   = state_q;
    stage_d   = stage_q;
    clk_cnt_d = clk_cnt_q;
    finish    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_ok_i) state_d = ST_RELEASE;
      ST_RELEASE: if (expire_i) begin
        if (both_hi) begin
          state_d = ST_PS_LOW;
          stage_d = PS_FIRST;
        end else begin
          state_d = ST_EXTRA_LOW;
        end
      end
      ST_PS_LOW: if (expire_i) state_d = ST_PS_HIGH;
      ST_PS_HIGH: if (expire_i) begin
        if (stage_q == PS_FINAL) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end else begin
          state_d   = ST_CLK_LOW;
          clk_cnt_d = '0;
        end
      end
      ST_EXTRA_LOW: if (expire_i) state_d = ST_EXTRA_HIGH;
      ST_EXTRA_HIGH: if (expire_i) begin
        if (both_hi) begin
          state_d = ST_PS_LOW;
          stage_d = PS_RETRY;
        end else begin
          state_d   = ST_CLK_LOW;
          clk_cnt_d = '0;
        end
      end
      ST_CLK_LOW: if (expire_i) state_d = ST_CLK_HIGH;
      ST_CLK_HIGH: if (expire_i) begin
        if (clk_cnt_q == CLK_LAST) begin
          if (both_hi) begin
            state_d = ST_PS_LOW;
            stage_d = PS_FINAL;
          end else begin
            state_d = ST_IDLE;
            finish  = 1'b1;
          end
        end else begin
          state_d   = ST_CLK_LOW;
          clk_cnt_d = clk_cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      stage_q   <= PS_FIRST;
      clk_cnt_q <= '0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      stage_q   <= stage_d;
      clk_cnt_q <= clk_cnt_d;
      done_q    <= finish;
      if (finish) ok_q <= both_hi;  // level at the final sample point
    end
  end

  assign scl_oe_o = (state_q == ST_EXTRA_LOW) || (state_q == ST_CLK_LOW);
  assign sda_oe_o = (state_q == ST_PS_LOW);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign bus_ok_o = ok_q;
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import i2c_rec_pkg::*;
#(
  parameter longint CLK_FREQ_HZ = 100_000_000,
  parameter int     HALF_US     = 5,
  parameter int     NUM_CLOCKS  = 9,
  parameter int     SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic periph_en_i,
  input  logic claim_ok_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic bus_ok_o
);
  localparam int HALF_CYC = half_cycles(CLK_FREQ_HZ, HALF_US);

  logic [1:0] line_s;
  logic       expire, start_ok;

  assign start_ok = start_i & ~periph_en_i & claim_ok_i;

  i2c_rec_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  i2c_rec_timer #(
    .HALF_CYC(HALF_CYC)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy_o),
    .expire_o(expire)
  );

  i2c_rec_fsm #(
    .NUM_CLOCKS(NUM_CLOCKS)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_ok_i(start_ok),
    .expire_i  (expire),
    .scl_s_i   (line_s[1]),
    .sda_s_i   (line_s[0]),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .bus_ok_o  (bus_ok_o)
  );
endmodule

// File: rtl/i2c_bus_recover_chk.sv
module i2c_bus_recover_chk #(
  parameter int HALF_CYC = 500
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic periph_en_i,
  input logic claim_ok_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic bus_ok_o
);
  logic [31:0] scl_run_q, sda_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_run_q <= '0;
      sda_run_q <= '0;
    end else begin
      scl_run_q <= scl_oe_o ? scl_run_q + 1 : '0;
      sda_run_q <= sda_oe_o ? sda_run_q + 1 : '0;
    end
  end

  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  p_blocked_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (periph_en_i || !claim_ok_i)) |=> !busy_o);

  p_accept_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !periph_en_i && claim_ok_i) |=> (busy_o && !scl_oe_o && !sda_oe_o));

  p_scl_low_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_run_q <= 32'(HALF_CYC));

  p_sda_low_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_run_q <= 32'(HALF_CYC));

  p_stop_scl_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> !scl_oe_o);

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_ok_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bus_ok_o) |-> done_o);
endmodule

bind i2c_bus_recover i2c_bus_recover_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .periph_en_i(periph_en_i),
  .claim_ok_i (claim_ok_i),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .bus_ok_o   (bus_ok_o)
);

// File: tb/i2c_bus_recover_tb.sv
module i2c_bus_recover_tb;
  localparam longint FREQ = 1_000_000;
  localparam int     HUS  = 5;
  localparam int     H    = 5;   // FREQ/1e6*HUS
  localparam int     NCLK = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, periph_en = 1'b0, claim_ok = 1'b1;
  logic scl_oe, sda_oe, busy, done, bus_ok;
  logic scl_stuck = 1'b0;
  int   hold_k = 0;

  int n_chk = 0, n_fail = 0;
  int scl_falls, sda_falls, bcyc, dcnt, first_drv, bad_len, scl_run, sda_run;
  logic scl_p, sda_p, mon_en = 1'b0;

  wire sda_hold = (hold_k > 0) && (scl_falls < hold_k);
  wire scl_line = !(scl_oe || scl_stuck);
  wire sda_line = !(sda_oe || sda_hold);

  always #5 clk = ~clk;

  i2c_bus_recover #(
    .CLK_FREQ_HZ(FREQ),
    .HALF_US    (HUS),
    .NUM_CLOCKS (NCLK),
    .SYNC_STAGES(2)
  ) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .periph_en_i(periph_en),
    .claim_ok_i (claim_ok),
    .scl_i      (scl_line),
    .sda_i      (sda_line),
    .scl_oe_o   (scl_oe),
    .sda_oe_o   (sda_oe),
    .busy_o     (busy),
    .done_o     (done),
    .bus_ok_o   (bus_ok)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    scl_falls = 0; sda_falls = 0; bcyc = 0; dcnt = 0; first_drv = -1;
    bad_len = 0; scl_run = 0; sda_run = 0; scl_p = 1'b0; sda_p = 1'b0;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if ((scl_oe && !scl_p) || (sda_oe && !sda_p))
        if (first_drv < 0) first_drv = bcyc;
      if (scl_oe && !scl_p) scl_falls++;
      if (sda_oe && !sda_p) sda_falls++;
      if (scl_oe) scl_run++;
      else begin
        if (scl_p && scl_run != H) bad_len++;
        scl_run = 0;
      end
      if (sda_oe) sda_run++;
      else begin
        if (sda_p && sda_run != H) bad_len++;
        sda_run = 0;
      end
      if (busy) bcyc++;
      if (done) dcnt++;
      scl_p = scl_oe;
      sda_p = sda_oe;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input int k, input bit stuck, input bit extra_start);
    int e_scl, e_ps, e_half, e_ok, b, c;
    bit fin;
    hold_k = k; scl_stuck = stuck;
    clear_mon();
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    if (stuck) begin
      e_scl = NCLK + 1; e_ps = 0; e_half = 1 + 2 + 2*NCLK; e_ok = 0;
    end else if (k == 0) begin
      e_scl = NCLK; e_ps = 2; e_half = 1 + 2 + 2*NCLK + 2; e_ok = 1;
    end else begin
      b = (k <= 1) ? 1 : 0;
      c = (k <= NCLK + 1) ? 1 : 0;
      e_scl = NCLK + 1; e_ps = b + c; e_half = 1 + 2 + 2*NCLK + 2*b + 2*c; e_ok = c;
    end
    pulse_start();
    if (extra_start) begin
      repeat (3*H) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    wait_done(fin);
    mon_en = 1'b0;
    check(fin, "R9 completion", int'(fin), 1);
    check(bcyc == e_half*H, extra_start ? "R10 busy length" : "R9 busy length", bcyc, e_half*H);
    check(scl_falls == e_scl, k == 0 ? "R7 scl pulses" : "R6 scl pulses", scl_falls, e_scl);
    check(sda_falls == e_ps, "R5 R8 pseudo-stop count", sda_falls, e_ps);
    check(first_drv == H, "R4 first drive index", first_drv, H);
    check(bad_len == 0, "R3 low interval length", bad_len, 0);
    check(dcnt == 1, "R9 done pulses", dcnt, 1);
    check(int'(bus_ok) == e_ok, "R11 bus_ok", int'(bus_ok), e_ok);
    check(!scl_oe && !sda_oe && !busy, "R9 lines released", int'({scl_oe, sda_oe, busy}), 0);
  endtask

  task automatic blocked_case(input bit pe, input bit cl);
    int seen;
    seen = 0;
    periph_en = pe; claim_ok = cl;
    pulse_start();
    for (int i = 0; i < 4*H; i++) begin
      @(negedge clk);
      if (busy || scl_oe || sda_oe || done) seen++;
    end
    check(seen == 0, "R2 blocked start", seen, 0);
    periph_en = 1'b0; claim_ok = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!scl_oe && !sda_oe && !busy && !done && !bus_ok, "R1 reset state",
          int'({scl_oe, sda_oe, busy, done, bus_ok}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!scl_oe && !sda_oe && !busy, "R1 idle after reset", int'({scl_oe, sda_oe, busy}), 0);
    blocked_case(1'b1, 1'b1);
    blocked_case(1'b0, 1'b0);
    blocked_case(1'b1, 1'b0);
    for (int k = 0; k <= 12; k++) run_case(k, 1'b0, 1'b0);
    run_case(0, 1'b1, 1'b0);
    run_case(3, 1'b1, 1'b0);
    run_case(0, 1'b0, 1'b1);   // R10 second start mid-sequence
    run_case(NCLK + 2, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200_000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule